// File: doc/BRIEF.md
# I2C Channel-Select Register Target

This block is an I2C target that holds the select state for a two-way downstream bus switch. A bus master addresses it and writes one control byte. The two low bits of that byte decide which of the two downstream segments get connected. A read returns those selections together with the present state of each segment's active-low interrupt line. The master can use this to find which segment raised an interrupt, and then connect that segment.

SCL and SDA arrive already synchronised to the block clock. The block drives SDA through an open-drain enable: when `sda_oe` is high, the line is pulled low. A newly written selection is held back until the master ends the transfer with a STOP, so a segment is never connected in the middle of a transfer. The active-low reset puts the protocol engine back in idle and disconnects both segments.

Top module: `chsel_i2c_target`

## Requirements
- R1: The target answers only the 7-bit address whose five upper bits are 1,1,1,0,0 and whose two low bits equal `strap_a[1:0]`, with `strap_a[1]` above `strap_a[0]`. The eighth bit selects the direction: 1 for a read, 0 for a write.
- R2: Bit 0 of a written byte selects channel 0 (`chan_en[0]`) and bit 1 selects channel 1 (`chan_en[1]`). Any of the four combinations is accepted, including both channels on.
- R3: When a single write transfer carries several data bytes, only the last byte received decides the selection.
- R4: A written selection does not change `chan_en` before a STOP is seen. It is applied on that STOP. A read issued before the STOP returns the selection that is still in force.
- R5: A read byte has bit 5 set when `irq_n[1]` is low and bit 4 set when `irq_n[0]` is low. Bits 1:0 hold the present `chan_en`. The interrupt inputs are sampled when each byte is loaded for sending.
- R6: While `rst_n` is low, `chan_en` is 0 and `sda_oe` is 0. A selection that was written but not yet applied is discarded.
- R7: The target acknowledges a matching address and every written data byte by pulling SDA low for the whole ninth clock. At all other times during a write it leaves SDA released.
- R8: During a read, an acknowledge from the master makes the target send another byte. A not-acknowledge makes it release SDA and stay silent until the next START.
- R9: After an address that does not match, SDA stays released for the rest of that transfer and the selection is left unchanged.
- R10: Bits 7:6 and 3:2 of a written byte are ignored. They read back as 0.
- R11: A repeated START, with no STOP before it, begins a new address phase, and that address phase works like the one after a plain START.
- R12: A STOP part-way through a byte abandons the transfer. The target then answers the next transfer normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at several times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset (pin or power-on) |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level as seen on the wire |
| strap_a | input | 2 | Address strap levels forming the two address LSBs |
| irq_n | input | 2 | Active-low interrupt lines of the two downstream segments |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| chan_en | output | 2 | Connect enables for downstream channels 1 and 0 |

## Verification
The assertions assume that SCL and SDA come from a well-behaved master. SDA changes while SCL is high only to form a START or a STOP. The master never raises SDA to make a STOP while the target holds the line low. Each SCL level lasts longer than one block clock, so every edge is seen as a separate event. The stimulus moves SDA only in the low phase of SCL, except in the START and STOP tasks. It holds each SCL phase for several clocks, and it issues a STOP only after it has clocked a NACK or after the target has released the line.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int NCHAN  = 2;

  localparam logic [4:0] ADDR_PREFIX = 5'b11100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } xfer_st_t;

  // True when a received 7-bit address selects this target.
  function automatic logic addr_match(input logic [6:0] adr, input logic [1:0] strap);
    return adr == {ADDR_PREFIX, strap};
  endfunction

  // Byte returned on a read: interrupt flags in bits 5:4, selection in 1:0.
  function automatic logic [BYTE_W-1:0] status_byte(input logic [NCHAN-1:0] irq_n,
                                                    input logic [NCHAN-1:0] en);
    return {2'b00, ~irq_n[1], ~irq_n[0], 2'b00, en};
  endfunction

endpackage

// File: rtl/chsel_bus_cond.sv
module chsel_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  assign start_evt = scl_in & scl_q & sda_q & ~sda_in;
  assign stop_evt  = scl_in & scl_q & ~sda_q & sda_in;
endmodule

// File: rtl/chsel_chan_reg.sv
module chsel_chan_reg
  import chsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [NCHAN-1:0] wr_sel,
  input  logic             stop_evt,
  output logic [NCHAN-1:0] chan_en
);
  logic [NCHAN-1:0] pend;
  logic             pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      pend_v  <= 1'b0;
      chan_en <= '0;
    end else begin
      if (wr_stb) begin
        pend   <= wr_sel;
        pend_v <= 1'b1;
      end
      if (stop_evt && pend_v) begin
        chan_en <= pend;
        pend_v  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chsel_xfer_fsm.sv
module chsel_xfer_fsm
  import chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_in,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [NCHAN-1:0]  wr_sel,
  output logic              addr_done,
  output logic              addr_hit,
  output logic              in_addr
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  xfer_st_t          st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              m_ack;

  assign in_addr   = (st == ST_ADDR);
  assign addr_done = in_addr && scl_fall && (cnt == CNT_FULL);
  assign addr_hit  = addr_match(sh[BYTE_W-1:1], strap);
  assign wr_stb    = (st == ST_WBYTE) && scl_fall && (cnt == CNT_FULL);
  assign wr_sel    = sh[NCHAN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      sda_oe <= 1'b0;
      m_ack  <= 1'b0;
    end else if (start_evt) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_in};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (sh[0]) begin
              tx     <= {rd_byte[BYTE_W-2:0], 1'b0};
              sda_oe <= ~rd_byte[BYTE_W-1];
              st     <= ST_RBYTE;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WBYTE;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_WBYTE;
          end
        end
        ST_RBYTE: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CNT_FULL) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              sda_oe <= ~tx[BYTE_W-1];
              tx     <= {tx[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_in;
          end else if (scl_fall) begin
            if (m_ack) begin
              cnt    <= '0;
              tx     <= {rd_byte[BYTE_W-2:0], 1'b0};
              sda_oe <= ~rd_byte[BYTE_W-1];
              st     <= ST_RBYTE;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chsel_i2c_target.sv
module chsel_i2c_target
  import chsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [1:0]       strap_a,
  input  logic [NCHAN-1:0] irq_n,
  output logic             sda_oe,
  output logic [NCHAN-1:0] chan_en
);
  logic              scl_rise, scl_fall;
  logic              start_evt, stop_evt;
  logic              wr_stb;
  logic [NCHAN-1:0]  wr_sel;
  logic              addr_done, addr_hit, in_addr;
  logic [BYTE_W-1:0] rd_byte;

  assign rd_byte = status_byte(irq_n, chan_en);

  chsel_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  chsel_xfer_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .strap     (strap_a),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_sel    (wr_sel),
    .addr_done (addr_done),
    .addr_hit  (addr_hit),
    .in_addr   (in_addr)
  );

  chsel_chan_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_sel   (wr_sel),
    .stop_evt (stop_evt),
    .chan_en  (chan_en)
  );
endmodule

// File: rtl/chsel_i2c_target_chk.sv
module chsel_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic [1:0] chan_en,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       addr_done,
  input logic       addr_hit,
  input logic       in_addr,
  input logic       wr_stb
);
  AST_EN_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en != $past(chan_en)) |-> $past(stop_evt)); // R4

  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> sda_oe); // R7

  AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in)) |-> $stable(sda_oe)); // R7

  AST_MISS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> (!sda_oe && !in_addr)); // R9

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (in_addr && !sda_oe)); // R11

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe); // R12
endmodule

bind chsel_i2c_target chsel_i2c_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .chan_en   (chan_en),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .addr_done (addr_done),
  .addr_hit  (addr_hit),
  .in_addr   (in_addr),
  .wr_stb    (wr_stb)
);

// File: tb/sim_chsel_i2c_target.sv
module sim_chsel_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [6:0] MY_ADR = 7'b1110010;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic [1:0] strap, irq_n;
  logic       sda_oe;
  logic [1:0] chan_en;
  logic       sda_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  logic [1:0] exp_q[$];
  logic [1:0] model_en = 2'b00;
  logic [1:0] seen     = 2'b00;
  logic [1:0] head;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  chsel_i2c_target u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_in  (scl_m),
    .sda_in  (sda_line),
    .strap_a (strap),
    .irq_n   (irq_n),
    .sda_oe  (sda_oe),
    .chan_en (chan_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic [1:0] irqn, input logic [1:0] en);
    logic [7:0] v = 8'h00;
    if (irqn[1] == 1'b0) v = v + 8'h20;
    if (irqn[0] == 1'b0) v = v + 8'h10;
    return v + {6'd0, en};
  endfunction

  task automatic expect_en(input logic [1:0] v);
    if (v != model_en) begin
      exp_q.push_back(v);
      model_en = v;
    end
  endtask

  // Monitor: every change of chan_en must match the next queued expectation.
  always @(negedge clk) begin
    if (mon_on && chan_en !== seen) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected chan_en change", {30'd0, chan_en}, {30'd0, seen});
      end else begin
        head = exp_q.pop_front();
        chk(chan_en === head, "R2 chan_en value", {30'd0, chan_en}, {30'd0, head});
      end
      seen = chan_en;
    end
  end

  task automatic wait_h();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;
    wait_h();
    scl_m = 1'b1;
    wait_h();
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1;
    wait_h();
    scl_m = 1'b1;
    repeat (HALF/2) @(posedge clk);
    #1;
    b = sda_line;
    repeat (HALF - HALF/2) @(posedge clk);
    #1;
    scl_m = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1;
    wait_h();
    scl_m = 1'b1;
    wait_h();
    sda_m = 1'b0;
    wait_h();
    scl_m = 1'b0;
  endtask

  task automatic do_stop();
    sda_m = 1'b0;
    wait_h();
    scl_m = 1'b1;
    wait_h();
    sda_m = 1'b1;
    wait_h();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic bit_v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(bit_v);
    ack = ~bit_v;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    logic bit_v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(bit_v);
      b[i] = bit_v;
    end
    put_bit(~give_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    irq_n = 2'b11;
    strap = 2'b10;
    repeat (5) @(posedge clk);
    #1;
    chk(chan_en == 2'b00 && sda_oe == 1'b0, "R6 reset state", {29'd0, sda_oe, chan_en}, 0);
    rst_n  = 1'b1;
    seen   = chan_en;
    mon_on = 1'b1;
    wait_h();

    // Write channel 0, held until STOP
    do_start();
    send_byte({MY_ADR, 1'b0}, ack);
    chk(ack, "R1 address ack on write", ack, 1);
    send_byte(8'h01, ack);
    chk(ack, "R7 data byte ack", ack, 1);
    wait_h();
    chk(chan_en == 2'b00, "R4 enable held before STOP", chan_en, 0);
    expect_en(2'b01);
    do_stop();
    chk(chan_en == 2'b01, "R2 channel 0 after STOP", chan_en, 1);

    // Read with channel 1 interrupt pending
    irq_n = 2'b01;
    do_start();
    send_byte({MY_ADR, 1'b1}, ack);
    chk(ack, "R1 address ack on read", ack, 1);
    read_byte(1'b0, rb);
    chk(rb == exp_status(irq_n, 2'b01), "R5 read status", rb, exp_status(irq_n, 2'b01));
    wait_h();
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    do_stop();

    // Several bytes, last one wins, unused bits dropped
    do_start();
    send_byte({MY_ADR, 1'b0}, ack);
    send_byte(8'h02, ack);
    send_byte(8'hFF, ack);
    chk(ack, "R3 second data byte ack", ack, 1);
    expect_en(2'b11);
    do_stop();
    chk(chan_en == 2'b11, "R3 last byte kept, both channels", chan_en, 3);
    irq_n = 2'b10;
    do_start();
    send_byte({MY_ADR, 1'b1}, ack);
    read_byte(1'b1, rb);
    chk(rb == exp_status(2'b10, 2'b11), "R10 unused bits read zero", rb, exp_status(2'b10, 2'b11));
    read_byte(1'b0, rb);
    chk(rb == exp_status(2'b10, 2'b11), "R8 second byte after master ACK", rb, exp_status(2'b10, 2'b11));
    do_stop();

    // Address mismatch: strap bits wrong, then prefix wrong
    do_start();
    send_byte({7'b1110001, 1'b0}, ack);
    chk(!ack, "R9 no ack on strap mismatch", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R9 no ack on data after mismatch", ack, 0);
    do_stop();
    chk(chan_en == 2'b11, "R9 selection unchanged", chan_en, 3);
    do_start();
    send_byte({7'b0110010, 1'b1}, ack);
    chk(!ack, "R1 no ack on prefix mismatch", ack, 0);
    do_stop();

    // Repeated START: write pending, read sees old selection, STOP applies
    do_start();
    send_byte({MY_ADR, 1'b0}, ack);
    send_byte(8'h00, ack);
    do_start();
    send_byte({MY_ADR, 1'b1}, ack);
    chk(ack, "R11 address ack after repeated START", ack, 1);
    read_byte(1'b0, rb);
    chk(rb == exp_status(irq_n, 2'b11), "R4 read before STOP shows applied", rb, exp_status(irq_n, 2'b11));
    expect_en(2'b00);
    do_stop();
    chk(chan_en == 2'b00, "R4 pending applied at STOP", chan_en, 0);

    // STOP inside the address byte, then a normal transfer
    do_start();
    put_bit(1'b1);
    put_bit(1'b1);
    put_bit(1'b1);
    do_stop();
    chk(sda_oe == 1'b0 && chan_en == 2'b00, "R12 aborted transfer", {29'd0, sda_oe, chan_en}, 0);
    do_start();
    send_byte({MY_ADR, 1'b0}, ack);
    chk(ack, "R12 answers after abort", ack, 1);
    send_byte(8'h02, ack);
    expect_en(2'b10);
    do_stop();
    chk(chan_en == 2'b10, "R2 channel 1 only", chan_en, 2);

    // Reset during a transfer with a pending write
    do_start();
    send_byte({MY_ADR, 1'b0}, ack);
    send_byte(8'h03, ack);
    expect_en(2'b00);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(chan_en == 2'b00 && sda_oe == 1'b0, "R6 reset mid transfer", {29'd0, sda_oe, chan_en}, 0);
    rst_n = 1'b1;
    do_stop();
    wait_h();
    chk(chan_en == 2'b00, "R6 pending discarded by reset", chan_en, 0);

    wait_h();
    chk(exp_q.size() == 0, "R4 all expected changes seen", exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule